// File: doc/BRIEF.md
# Sub-Pipelined AES-128 Encryption Engine

This block encrypts 128-bit blocks with AES-128 at a rate of one block every two clock cycles under sustained load. Five round slots are built in hardware. Each slot is split into two register stages. The first stage does nothing but byte substitution on all sixteen bytes, which keeps the S-box as the only logic between its registers. The second stage does the row shift, the column mix and the round-key XOR. A block runs through the ten stages once for rounds 1 to 5. It then re-enters the first stage and runs through again for rounds 6 to 10. On this second pass the last slot skips the column mix. The first four slots always mix and contain no bypass path.

Key expansion is done outside the block. The eleven round keys are written one at a time through a simple write port and held in internal registers. Round key 0 is XORed into the plaintext as it enters the pipeline. A block coming back for its second pass has priority over new input at the pipeline entry, and a ready output tells the source when it can deliver a new block. Results leave in acceptance order with a one-cycle valid strobe.

Top module: `aes_sp_enc`

## Requirements
- R1: `out_data_o` is the AES-128 encryption of the accepted plaintext under round keys 0 to 10 stored at key indices 0 to 10. Index 0 is the initial whitening key and index 10 is the final-round key, applied without column mixing. Byte 0 of each 128-bit block, key and result sits in bits 127:120, and bytes fill the 4x4 state column by column.
- R2: A plaintext is accepted on a rising edge where `in_valid_i` and `in_ready_o` are both high. Its result is presented with `out_valid_o` high in the cycle that follows the 19th rising edge after that accepting edge.
- R3: `in_ready_o` is low exactly while a block that has finished its first pass occupies the last stage. A plaintext offered in such a cycle is not taken and produces no result. `in_ready_o` is high in every cycle where `out_valid_o` is high.
- R4: Every accepted block yields exactly one result. Results come out in acceptance order, and `out_valid_o` is never high without an outstanding block.
- R5: From an empty pipeline with `in_valid_i` held high, ten blocks are accepted on ten consecutive edges. `in_ready_o` then stays low for ten cycles, so fourteen blocks need 24 cycles to be accepted. No more than ten blocks are in flight at once.
- R6: A rising edge with `key_we_i` high stores `key_data_i` as round key `key_idx_i` for indices 0 to 10. A write to indices 11 to 15 changes no stored key, and keys are held until they are rewritten.
- R7: `rst_ni` low asynchronously empties the pipeline and clears all round keys. During and after reset `out_valid_o` is low and `in_ready_o` is high, and blocks that were in flight when reset arrived never produce a result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_we_i | input | 1 | Round-key write strobe |
| key_idx_i | input | 4 | Round-key index to write (0 to 10) |
| key_data_i | input | 128 | Round-key value |
| in_valid_i | input | 1 | Plaintext valid |
| in_data_i | input | 128 | Plaintext block |
| in_ready_o | output | 1 | Entry stage free for a new plaintext |
| out_valid_o | output | 1 | Ciphertext valid, one cycle per block |
| out_data_o | output | 128 | Ciphertext block |

## Verification
Three published known-answer vectors check the pass-dependent key selection and the column-mix bypass on the final round. If the bypass fired on the first pass or never fired at all, or if the slots took keys 1 to 5 twice, every ciphertext would be wrong. A back-to-back stream of fourteen blocks fills the pipeline until recirculation collides with fresh input. A design that let new data win at the entry would drop or corrupt blocks, reorder results, or show the wrong ready pattern. Further tests write key indices above 10 and then confirm that encryption is unchanged, and assert reset while blocks are mid-flight to catch any stale output that leaks out after release.

// File: rtl/aes_sp_pkg.sv
package aes_sp_pkg;

  localparam int BLK_W  = 128;
  localparam int NBYTES = BLK_W / 8;

  typedef logic [BLK_W-1:0] blk_t;

  typedef struct packed {
    logic vld;
    logic pass;   // 0: rounds of first pass, 1: second pass
    blk_t data;
  } stg_t;

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r;
    logic [7:0] s;
    r = 8'h00;
    s = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = r ^ s;
      s = xt(s);
    end
    return r;
  endfunction

  // x^254 by square-and-multiply; maps 0 to 0
  function automatic logic [7:0] gf_inv(input logic [7:0] x);
    logic [7:0] r;
    logic [7:0] sq;
    r  = 8'h01;
    sq = x;
    for (int i = 1; i < 8; i++) begin
      sq = gf_mul(sq, sq);
      r  = gf_mul(r, sq);
    end
    return r;
  endfunction

  function automatic logic [7:0] rol8(input logic [7:0] b, input int n);
    return (b << n) | (b >> (8 - n));
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] x);
    logic [7:0] b;
    b = gf_inv(x);
    return b ^ rol8(b, 1) ^ rol8(b, 2) ^ rol8(b, 3) ^ rol8(b, 4) ^ 8'h63;
  endfunction

  function automatic blk_t sub_bytes(input blk_t s);
    blk_t o;
    for (int i = 0; i < NBYTES; i++) o[8*i +: 8] = sbox(s[8*i +: 8]);
    return o;
  endfunction

  // byte k of the state lives at bits BLK_W-1-8k downto BLK_W-8-8k, k = row + 4*col
  function automatic blk_t shift_rows(input blk_t s);
    blk_t o;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[BLK_W-1-8*(r+4*c) -: 8] = s[BLK_W-1-8*(r+4*((c+r)%4)) -: 8];
    return o;
  endfunction

  function automatic blk_t mix_cols(input blk_t s);
    blk_t o;
    logic [7:0] a0, a1, a2, a3;
    for (int c = 0; c < 4; c++) begin
      a0 = s[BLK_W-1-32*c  -: 8];
      a1 = s[BLK_W-9-32*c  -: 8];
      a2 = s[BLK_W-17-32*c -: 8];
      a3 = s[BLK_W-25-32*c -: 8];
      o[BLK_W-1-32*c  -: 8] = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
      o[BLK_W-9-32*c  -: 8] = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
      o[BLK_W-17-32*c -: 8] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
      o[BLK_W-25-32*c -: 8] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
    end
    return o;
  endfunction

endpackage

// File: rtl/aes_sp_key_bank.sv
module aes_sp_key_bank
  import aes_sp_pkg::*;
#(
  parameter int NKEYS  = 11,
  parameter int KIDX_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [KIDX_W-1:0] idx_i,
  input  blk_t              data_i,
  output blk_t              keys_o [NKEYS]
);

  for (genvar g = 0; g < NKEYS; g++) begin : g_key
    blk_t key_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                key_q <= '0;
      else if (we_i && idx_i == KIDX_W'(g))       key_q <= data_i;
    end
    assign keys_o[g] = key_q;
  end

endmodule

// File: rtl/aes_sp_sub_stage.sv
module aes_sp_sub_stage
  import aes_sp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  stg_t in_i,
  output stg_t out_o
);

  stg_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= '{vld: in_i.vld, pass: in_i.pass, data: sub_bytes(in_i.data)};
  end

  assign out_o = q;

endmodule

// File: rtl/aes_sp_mix_stage.sv
module aes_sp_mix_stage
  import aes_sp_pkg::*;
#(
  parameter bit HAS_BYPASS = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  stg_t in_i,
  input  blk_t key_p0_i,
  input  blk_t key_p1_i,
  output stg_t out_o
);

  blk_t shifted;
  blk_t mixed;
  blk_t rnd_out;
  blk_t key_sel;
  stg_t q;

  assign shifted = shift_rows(in_i.data);
  assign mixed   = mix_cols(shifted);
  assign key_sel = in_i.pass ? key_p1_i : key_p0_i;

  if (HAS_BYPASS) begin : g_bypass
    // final round of the second pass has no column mix
    assign rnd_out = in_i.pass ? shifted : mixed;
  end else begin : g_fixed
    assign rnd_out = mixed;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= '{vld: in_i.vld, pass: in_i.pass, data: rnd_out ^ key_sel};
  end

  assign out_o = q;

endmodule

// File: rtl/aes_sp_enc.sv
module aes_sp_enc
  import aes_sp_pkg::*;
#(
  parameter  int SLOTS  = 5,
  localparam int NKEYS  = 2 * SLOTS + 1,
  localparam int KIDX_W = $clog2(NKEYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              key_we_i,
  input  logic [KIDX_W-1:0] key_idx_i,
  input  logic [BLK_W-1:0]  key_data_i,
  input  logic              in_valid_i,
  input  logic [BLK_W-1:0]  in_data_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [BLK_W-1:0]  out_data_o
);

  blk_t key_q [NKEYS];
  stg_t sub_q [SLOTS];
  stg_t mix_q [SLOTS];
  stg_t entry;
  stg_t last;
  logic recirc;

  aes_sp_key_bank #(
    .NKEYS  (NKEYS),
    .KIDX_W (KIDX_W)
  ) u_keys (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (key_we_i),
    .idx_i  (key_idx_i),
    .data_i (key_data_i),
    .keys_o (key_q)
  );

  assign last   = mix_q[SLOTS-1];
  assign recirc = last.vld && !last.pass;

  // returning blocks own the entry; fresh input is whitened with key 0
  always_comb begin
    entry.vld  = recirc || in_valid_i;
    entry.pass = recirc;
    entry.data = recirc ? last.data : (in_data_i ^ key_q[0]);
  end

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    stg_t sub_in;

    if (k == 0) begin : g_head
      assign sub_in = entry;
    end else begin : g_chain
      assign sub_in = mix_q[k-1];
    end

    aes_sp_sub_stage u_sub (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .in_i   (sub_in),
      .out_o  (sub_q[k])
    );

    aes_sp_mix_stage #(
      .HAS_BYPASS (k == SLOTS - 1)
    ) u_mix (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .in_i     (sub_q[k]),
      .key_p0_i (key_q[k + 1]),
      .key_p1_i (key_q[k + 1 + SLOTS]),
      .out_o    (mix_q[k])
    );
  end

  assign in_ready_o  = !recirc;
  assign out_valid_o = last.vld && last.pass;
  assign out_data_o  = last.data;

endmodule

// File: rtl/aes_sp_enc_chk.sv
module aes_sp_enc_chk
  import aes_sp_pkg::*;
#(
  parameter  int SLOTS  = 5,
  localparam int NKEYS  = 2 * SLOTS + 1,
  localparam int KIDX_W = $clog2(NKEYS),
  localparam int NST    = 2 * SLOTS,
  localparam int LAT    = 4 * SLOTS - 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              ready_i,
  input logic              out_vld_i,
  input logic              key_we_i,
  input logic [KIDX_W-1:0] key_idx_i,
  input logic              s0_vld_i,
  input logic              s0_pass_i,
  input blk_t              keys_i [NKEYS]
);

  logic [7:0] outst;
  logic [7:0] since_rst;
  blk_t       key_fold;
  logic       acc;

  assign acc = in_valid_i && ready_i;

  always_comb begin
    key_fold = '0;
    for (int i = 0; i < NKEYS; i++) key_fold = key_fold ^ keys_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      outst     <= '0;
      since_rst <= '0;
    end else begin
      outst <= outst + 8'(acc) - 8'(out_vld_i);
      if (since_rst != 8'hff) since_rst <= since_rst + 8'd1;
    end
  end

  assert_take_new_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && ready_i) |=> (s0_vld_i && !s0_pass_i));

  assert_return_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |=> (s0_vld_i && s0_pass_i));

  assert_ready_on_out_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_i |-> ready_i);

  assert_no_phantom_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_i |-> (outst != 8'd0));

  assert_in_flight_cap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    outst <= 8'(NST));

  assert_key_ignore_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_we_i && key_idx_i >= KIDX_W'(NKEYS)) |=> $stable(key_fold));

  assert_quiet_after_reset_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst <= 8'(LAT)) |-> !out_vld_i);

endmodule

bind aes_sp_enc aes_sp_enc_chk #(.SLOTS(SLOTS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .ready_i    (in_ready_o),
  .out_vld_i  (out_valid_o),
  .key_we_i   (key_we_i),
  .key_idx_i  (key_idx_i),
  .s0_vld_i   (sub_q[0].vld),
  .s0_pass_i  (sub_q[0].pass),
  .keys_i     (key_q)
);

// File: tb/tb_aes_sp_enc.sv
`timescale 1ns/1ps
module tb_aes_sp_enc;

  localparam int NSTR = 14;
  localparam int LAT  = 19;
  localparam int MAXL = 64;

  // key, plaintext, ciphertext
  localparam logic [127:0] VEC [3][3] = '{
    '{128'h0, 128'h0, 128'h66e94bd4ef8a2c3b884cfa59ca342b2e},
    '{128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h3243f6a8885a308d313198a2e0370734,
      128'h3925841d02dc09fbdc118597196a0b32},
    '{128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff,
      128'h69c4e0d86a7b0430d8cdb78070b4c55a}
  };

  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic         key_we_i;
  logic [3:0]   key_idx_i;
  logic [127:0] key_data_i;
  logic         in_valid_i;
  logic [127:0] in_data_i;
  logic         in_ready_o;
  logic         out_valid_o;
  logic [127:0] out_data_o;

  aes_sp_enc dut (
    .clk_i, .rst_ni, .key_we_i, .key_idx_i, .key_data_i,
    .in_valid_i, .in_data_i, .in_ready_o, .out_valid_o, .out_data_o
  );

  always #2 clk_i = ~clk_i;

  int n_cmp = 0, n_bad = 0;
  int cyc = 0, n_acc = 0, n_obs = 0;
  int acc_cyc [MAXL];
  int obs_cyc [MAXL];
  logic [127:0] obs_data [MAXL];
  logic [7:0]   sb [256];
  logic [127:0] rk [11];
  bit done = 0;

  always @(posedge clk_i) begin
    cyc++;
    if (rst_ni && in_valid_i && in_ready_o && n_acc < MAXL) begin
      acc_cyc[n_acc] = cyc;
      n_acc++;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && out_valid_o && n_obs < MAXL) begin
      obs_cyc[n_obs]  = cyc;
      obs_data[n_obs] = out_data_o;
      n_obs++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] m2(input logic [7:0] b);
    return (b << 1) ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] rl(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  // S-box table from paired multiply-by-3 / divide-by-3 walk
  task automatic build_sbox();
    logic [7:0] p, q, x;
    p = 8'h01; q = 8'h01;
    do begin
      p = p ^ (p << 1) ^ (p[7] ? 8'h1b : 8'h00);
      q = q ^ (q << 1);
      q = q ^ (q << 2);
      q = q ^ (q << 4);
      if (q[7]) q = q ^ 8'h09;
      x = q ^ rl(q, 1) ^ rl(q, 2) ^ rl(q, 3) ^ rl(q, 4);
      sb[p] = x ^ 8'h63;
    end while (p != 8'h01);
    sb[0] = 8'h63;
  endtask

  task automatic expand(input logic [127:0] k);
    logic [31:0] w [44];
    logic [31:0] t;
    logic [7:0]  rc;
    for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
    rc = 8'h01;
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {sb[t[31:24]], sb[t[23:16]], sb[t[15:8]], sb[t[7:0]]} ^ {rc, 24'h0};
        rc = m2(rc);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r < 11; r++) rk[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endtask

  function automatic logic [127:0] ref_enc(input logic [127:0] pt);
    logic [7:0] st [16];
    logic [7:0] t  [16];
    logic [127:0] o;
    for (int i = 0; i < 16; i++) st[i] = pt[127-8*i -: 8] ^ rk[0][127-8*i -: 8];
    for (int r = 1; r <= 10; r++) begin
      for (int i = 0; i < 16; i++) st[i] = sb[st[i]];
      for (int c = 0; c < 4; c++)
        for (int w = 0; w < 4; w++) t[w+4*c] = st[w+4*((c+w)%4)];
      for (int c = 0; c < 4; c++) begin
        if (r != 10) begin
          st[4*c]   = m2(t[4*c]) ^ m2(t[4*c+1]) ^ t[4*c+1] ^ t[4*c+2] ^ t[4*c+3];
          st[4*c+1] = t[4*c] ^ m2(t[4*c+1]) ^ m2(t[4*c+2]) ^ t[4*c+2] ^ t[4*c+3];
          st[4*c+2] = t[4*c] ^ t[4*c+1] ^ m2(t[4*c+2]) ^ m2(t[4*c+3]) ^ t[4*c+3];
          st[4*c+3] = m2(t[4*c]) ^ t[4*c] ^ t[4*c+1] ^ t[4*c+2] ^ m2(t[4*c+3]);
        end else begin
          for (int w = 0; w < 4; w++) st[4*c+w] = t[4*c+w];
        end
      end
      for (int i = 0; i < 16; i++) st[i] = st[i] ^ rk[r][127-8*i -: 8];
    end
    for (int i = 0; i < 16; i++) o[127-8*i -: 8] = st[i];
    return o;
  endfunction

  task automatic load_keys();
    for (int i = 0; i < 11; i++) begin
      key_we_i = 1'b1; key_idx_i = 4'(i); key_data_i = rk[i];
      @(negedge clk_i);
    end
    key_we_i = 1'b0;
  endtask

  task automatic send_one(input logic [127:0] pt);
    bit r;
    in_valid_i = 1'b1; in_data_i = pt;
    do begin
      r = in_ready_o;
      @(negedge clk_i);
    end while (!r);
    in_valid_i = 1'b0;
  endtask

  task automatic wait_obs(input int target);
    for (int i = 0; i < 200 && n_obs < target; i++) @(negedge clk_i);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int base;
    int ncyc;
    logic [127:0] pts [NSTR];
    rst_ni = 1'b0; key_we_i = 1'b0; key_idx_i = '0; key_data_i = '0;
    in_valid_i = 1'b0; in_data_i = '0;
    build_sbox();
    repeat (3) @(negedge clk_i);
    chk(out_valid_o == 1'b0, "R7 reset out_valid", 128'(out_valid_o), 128'd0);
    chk(in_ready_o == 1'b1, "R7 reset in_ready", 128'(in_ready_o), 128'd1);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // known-answer table
    for (int v = 0; v < 3; v++) begin
      expand(VEC[v][0]);
      chk(ref_enc(VEC[v][1]) == VEC[v][2], "R1 bench model vs vector", ref_enc(VEC[v][1]), VEC[v][2]);
      load_keys();
      base = n_obs;
      send_one(VEC[v][1]);
      wait_obs(base + 1);
      chk(n_obs == base + 1, "R4 one result per block", 128'(n_obs), 128'(base + 1));
      chk(obs_data[base] == VEC[v][2], "R1 known-answer ciphertext", obs_data[base], VEC[v][2]);
      chk(obs_cyc[base] - acc_cyc[base] == LAT, "R2 latency",
          128'(obs_cyc[base] - acc_cyc[base]), 128'(LAT));
    end

    // out-of-range key writes must leave keys intact (R6)
    for (int i = 11; i < 16; i++) begin
      key_we_i = 1'b1; key_idx_i = 4'(i); key_data_i = {4{32'hdeadbeef}} ^ 128'(i);
      @(negedge clk_i);
    end
    key_we_i = 1'b0;
    base = n_obs;
    send_one(VEC[2][1]);
    wait_obs(base + 1);
    chk(obs_data[base] == VEC[2][2], "R6 index above 10 ignored", obs_data[base], VEC[2][2]);

    // back-to-back stream from empty pipeline
    for (int i = 0; i < NSTR; i++)
      pts[i] = {32'(i), 32'h5a5a0000 + 32'(i), ~32'(i), 32'hc0ffee00 ^ 32'(i * 7)};
    base = n_obs;
    ncyc = 0;
    for (int i = 0; i < NSTR;) begin
      bit r;
      in_valid_i = 1'b1; in_data_i = pts[i];
      r = in_ready_o;
      @(negedge clk_i);
      ncyc++;
      if (r) i++;
    end
    in_valid_i = 1'b0;
    chk(ncyc == 24, "R5 stream accept cycles", 128'(ncyc), 128'd24);
    chk(acc_cyc[base + 9] - acc_cyc[base] == 9, "R5 ten consecutive accepts",
        128'(acc_cyc[base + 9] - acc_cyc[base]), 128'd9);
    chk(acc_cyc[base + 10] - acc_cyc[base + 9] == 11, "R3 ten stalled cycles",
        128'(acc_cyc[base + 10] - acc_cyc[base + 9]), 128'd11);
    wait_obs(base + NSTR);
    repeat (30) @(negedge clk_i);
    chk(n_obs == base + NSTR, "R4 stream result count", 128'(n_obs), 128'(base + NSTR));
    for (int i = 0; i < NSTR; i++) begin
      chk(obs_data[base + i] == ref_enc(pts[i]), "R4 stream order/data R1",
          obs_data[base + i], ref_enc(pts[i]));
      chk(obs_cyc[base + i] - acc_cyc[base + i] == LAT, "R2 stream latency",
          128'(obs_cyc[base + i] - acc_cyc[base + i]), 128'(LAT));
    end

    // reset with blocks in flight
    base = n_obs;
    send_one(pts[0]);
    send_one(pts[1]);
    send_one(pts[2]);
    repeat (6) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk(out_valid_o == 1'b0, "R7 out_valid in reset", 128'(out_valid_o), 128'd0);
    chk(in_ready_o == 1'b1, "R7 in_ready in reset", 128'(in_ready_o), 128'd1);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (40) @(negedge clk_i);
    chk(n_obs == base, "R7 flushed blocks silent", 128'(n_obs), 128'(base));
    chk(in_ready_o == 1'b1, "R7 ready after reset", 128'(in_ready_o), 128'd1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule